// File: doc/BRIEF.md
# Next-Fetch-Address Branch Predictor

This block guesses the address that instruction fetch should request next. In every cycle it receives the current fetch PC. It returns a taken flag and a predicted next PC, and it does this combinationally within the same cycle. Three structures produce the guess:

- A direct-mapped target buffer holds tagged targets. It only ever holds branches that were seen to be taken.
- A table of 2-bit saturating direction counters is indexed by the PC.
- A circular return-address stack supplies the targets of subroutine returns.

The execute stage sends back resolved branches. Each resolution carries the branch PC, the actual direction, the actual target, and call and return flags. These resolutions train all three structures on the next clock edge. Recovery from a misprediction and pipeline squash are handled outside this block.

Top module: `next_fetch_predictor`

## Requirements
- R1: After reset every target-buffer entry is invalid, every direction counter holds 1 (weakly not taken) and the return stack is empty, so every fetch PC predicts not taken with next PC = PC+4.
- R2: On a target-buffer miss the outputs are taken = 0 and next PC = PC+4.
- R3: The target buffer index is PC[2 +: log2(BTB_ENTRIES)] and the tag is the PC bits above the index. A resolution with taken = 1 writes the valid bit, the tag, the target and the return flag at that index. A resolution with taken = 0 neither allocates nor changes any entry.
- R4: A valid entry whose tag differs from the fetch PC's tag is a miss.
- R5: The direction counter is indexed by PC[2 +: log2(BHT_ENTRIES)]. A taken resolution adds 1 to the counter, saturating at 3. A not-taken resolution subtracts 1, saturating at 0. On a hit, counter values 2 and 3 predict taken, with next PC = the stored target.
- R6: On a hit whose counter is 0 or 1, and which is not a return served by the stack, the outputs are taken = 0 and next PC = PC+4.
- R7: A later taken resolution of the same branch replaces its stored target, so the prediction uses the most recent actual target.
- R8: A resolution flagged as a call pushes PC+4 onto the return stack. A resolution flagged as a return (and not as a call) pops the stack. A hit on an entry marked as a return, while the stack is not empty, predicts taken with next PC = the stack top, whatever the counter holds.
- R9: A hit on a return entry while the stack is empty falls back to the counter and stored-target rule of R5 and R6.
- R10: The stack holds RAS_DEPTH entries and works as a circular buffer. A push onto a full stack overwrites the oldest entry. Popping an empty stack leaves it empty.
- R11: A resolution changes the predictions only from the clock edge on which it is written. A lookup in the same cycle still sees the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | ADDR_W | Current fetch address |
| pred_taken_o | output | 1 | Predicted taken |
| pred_pc_o | output | ADDR_W | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolution is presented this cycle |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction |
| upd_target_i | input | ADDR_W | Actual target address |
| upd_is_call_i | input | 1 | Resolved branch is a subroutine call |
| upd_is_ret_i | input | 1 | Resolved branch is a subroutine return |

## Verification
The bench builds the block with 4 target entries, 8 direction counters and a 4-deep return stack, keeping ADDR_W = 32. With a buffer this small, tag aliasing on a shared index occurs within a few resolutions. Five calls are enough to wrap the stack. A random resolution stream over a 32-address window is then compared against an arithmetic model after every update, at every address in that window.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
  typedef enum logic [1:0] {
    CNT_STRONG_NT = 2'd0,
    CNT_WEAK_NT   = 2'd1,
    CNT_WEAK_T    = 2'd2,
    CNT_STRONG_T  = 2'd3
  } dir_cnt_e;

  function automatic dir_cnt_e cnt_step(dir_cnt_e c, logic taken);
    dir_cnt_e n;
    n = c;
    unique case (c)
      CNT_STRONG_NT: n = taken ? CNT_WEAK_NT  : CNT_STRONG_NT;
      CNT_WEAK_NT:   n = taken ? CNT_WEAK_T   : CNT_STRONG_NT;
      CNT_WEAK_T:    n = taken ? CNT_STRONG_T : CNT_WEAK_NT;
      CNT_STRONG_T:  n = taken ? CNT_STRONG_T : CNT_WEAK_T;
      default:       n = CNT_WEAK_NT;
    endcase
    return n;
  endfunction

  function automatic logic cnt_says_taken(dir_cnt_e c);
    return c[1];
  endfunction
endpackage

// File: rtl/nfp_target_buf.sv
module nfp_target_buf #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_target_o,
  output logic              lk_is_ret_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic [ADDR_W-1:0] wr_target_i,
  input  logic              wr_is_ret_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [ENTRIES-1:0] ret_q;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;

  assign lk_idx = lk_pc_i[2 +: IDX_W];
  assign lk_tag = lk_pc_i[ADDR_W-1 -: TAG_W];
  assign wr_idx = wr_pc_i[2 +: IDX_W];
  assign wr_tag = wr_pc_i[ADDR_W-1 -: TAG_W];

  assign lk_hit_o    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_target_o = tgt_q[lk_idx];
  assign lk_is_ret_o = ret_q[lk_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ret_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= 1'b1;
      ret_q[wr_idx]   <= wr_is_ret_i;
      tag_q[wr_idx]   <= wr_tag;
      tgt_q[wr_idx]   <= wr_target_i;
    end
  end

  // R3
  alloc_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));

  // R3
  no_alloc_keeps_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q));
endmodule

// File: rtl/nfp_dir_table.sv
module nfp_dir_table
  import nfp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              lk_taken_o,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  dir_cnt_e         cnt_q [ENTRIES];
  logic [IDX_W-1:0] lk_idx, upd_idx;

  assign lk_idx     = lk_pc_i[2 +: IDX_W];
  assign upd_idx    = upd_pc_i[2 +: IDX_W];
  assign lk_taken_o = cnt_says_taken(cnt_q[lk_idx]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CNT_WEAK_NT;
    end else if (upd_en_i) begin
      cnt_q[upd_idx] <= cnt_step(cnt_q[upd_idx], upd_taken_i);
    end
  end

  // R5
  floor_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && cnt_q[upd_idx] == CNT_STRONG_NT)
      |=> cnt_q[$past(upd_idx)] == CNT_STRONG_NT);

  // R5
  ceil_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && cnt_q[upd_idx] == CNT_STRONG_T)
      |=> cnt_q[$past(upd_idx)] == CNT_STRONG_T);
endmodule

// File: rtl/nfp_return_stack.sv
module nfp_return_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] top_o,
  output logic              empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_idx;

  assign top_idx = ptr_q - PTR_W'(1);
  assign top_o   = mem_q[top_idx];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_addr_i;
      ptr_q        <= ptr_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o);

  // R10
  full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH));

  // R8
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (!empty_o && top_o == $past(push_addr_i)));
endmodule

// File: rtl/next_fetch_predictor.sv
module next_fetch_predictor #(
  parameter int ADDR_W      = 32,
  parameter int BTB_ENTRIES = 64,
  parameter int BHT_ENTRIES = 256,
  parameter int RAS_DEPTH   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_is_call_i,
  input  logic              upd_is_ret_i
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic              btb_hit, btb_is_ret, dir_taken, ras_empty;
  logic [ADDR_W-1:0] btb_target, ras_top, seq_pc;

  nfp_target_buf #(.ADDR_W(ADDR_W), .ENTRIES(BTB_ENTRIES)) u_tbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_pc_i     (fetch_pc_i),
    .lk_hit_o    (btb_hit),
    .lk_target_o (btb_target),
    .lk_is_ret_o (btb_is_ret),
    .wr_en_i     (upd_valid_i && upd_taken_i),
    .wr_pc_i     (upd_pc_i),
    .wr_target_i (upd_target_i),
    .wr_is_ret_i (upd_is_ret_i)
  );

  nfp_dir_table #(.ADDR_W(ADDR_W), .ENTRIES(BHT_ENTRIES)) u_dir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_pc_i     (fetch_pc_i),
    .lk_taken_o  (dir_taken),
    .upd_en_i    (upd_valid_i),
    .upd_pc_i    (upd_pc_i),
    .upd_taken_i (upd_taken_i)
  );

  nfp_return_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (upd_valid_i && upd_is_call_i),
    .push_addr_i (upd_pc_i + INSN_BYTES),
    .pop_i       (upd_valid_i && upd_is_ret_i && !upd_is_call_i),
    .top_o       (ras_top),
    .empty_o     (ras_empty)
  );

  assign seq_pc = fetch_pc_i + INSN_BYTES;

  always_comb begin
    pred_taken_o = 1'b0;
    pred_pc_o    = seq_pc;
    if (btb_hit && btb_is_ret && !ras_empty) begin
      pred_taken_o = 1'b1;
      pred_pc_o    = ras_top;
    end else if (btb_hit && dir_taken) begin
      pred_taken_o = 1'b1;
      pred_pc_o    = btb_target;
    end
  end

  // R2
  miss_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !btb_hit |-> (!pred_taken_o && pred_pc_o == seq_pc));

  // R8
  ret_uses_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (btb_hit && btb_is_ret && !ras_empty) |-> (pred_taken_o && pred_pc_o == ras_top));
endmodule

// File: tb/next_fetch_predictor_bench.sv
module next_fetch_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0;
  logic          pred_taken_o;
  logic [AW-1:0] pred_pc_o;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_pc_i = '0;
  logic          upd_taken_i = 1'b0;
  logic [AW-1:0] upd_target_i = '0;
  logic          upd_is_call_i = 1'b0;
  logic          upd_is_ret_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  next_fetch_predictor #(.ADDR_W(AW), .BTB_ENTRIES(4), .BHT_ENTRIES(8), .RAS_DEPTH(4))
    u_next_fetch_predictor (.*);

  // model: 4 target entries, 8 counters, 4-deep stack
  bit          m_valid [4];
  logic [29:0] m_tag   [4];
  logic [31:0] m_tgt   [4];
  bit          m_ret   [4];
  int          m_cnt   [8];
  logic [31:0] m_ras   [4];
  int          m_sp = 0;
  int          m_n  = 0;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_valid[i] = 0; m_ret[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    for (int i = 0; i < 8; i++) m_cnt[i] = 1;
    m_sp = 0; m_n = 0;
  endtask

  task automatic model_pred(input logic [31:0] pc, output logic t, output logic [31:0] n);
    int bi, ci;
    bit hit;
    bi  = int'(pc[3:2]);
    ci  = int'(pc[4:2]);
    hit = m_valid[bi] && (m_tag[bi] == pc[31:4]);
    if (hit && m_ret[bi] && m_n > 0) begin t = 1; n = m_ras[(m_sp + 3) % 4]; end
    else if (hit && m_cnt[ci] >= 2) begin t = 1; n = m_tgt[bi]; end
    else begin t = 0; n = pc + 32'd4; end
  endtask

  task automatic model_upd(input logic [31:0] pc, input bit tk, input logic [31:0] tg,
                           input bit c, input bit r);
    int bi, ci;
    bi = int'(pc[3:2]);
    ci = int'(pc[4:2]);
    if (tk && m_cnt[ci] < 3) m_cnt[ci]++;
    if (!tk && m_cnt[ci] > 0) m_cnt[ci]--;
    if (tk) begin m_valid[bi] = 1; m_tag[bi] = pc[31:4]; m_tgt[bi] = tg; m_ret[bi] = r; end
    if (c) begin
      m_ras[m_sp] = pc + 32'd4;
      m_sp = (m_sp + 1) % 4;
      if (m_n < 4) m_n++;
    end else if (r && m_n > 0) begin
      m_sp = (m_sp + 3) % 4;
      m_n--;
    end
  endtask

  task automatic look_exp(input logic [31:0] pc, input bit et, input logic [31:0] en, input string req);
    fetch_pc_i = pc;
    #1;
    checks++;
    if (pred_taken_o !== et || pred_pc_o !== en) begin
      errors++;
      $display("FAIL %s pc=%h actual taken=%b next=%h expected taken=%b next=%h",
               req, pc, pred_taken_o, pred_pc_o, et, en);
    end
  endtask

  task automatic look_model(input logic [31:0] pc, input string req);
    logic t;
    logic [31:0] n;
    model_pred(pc, t, n);
    look_exp(pc, t, n, req);
  endtask

  task automatic drive_upd(input logic [31:0] pc, input bit tk, input logic [31:0] tg,
                           input bit c, input bit r);
    upd_valid_i = 1; upd_pc_i = pc; upd_taken_i = tk; upd_target_i = tg;
    upd_is_call_i = c; upd_is_ret_i = r;
  endtask

  task automatic upd(input logic [31:0] pc, input bit tk, input logic [31:0] tg,
                     input bit c, input bit r);
    @(negedge clk_i);
    drive_upd(pc, tk, tg, c, r);
    @(posedge clk_i);
    model_upd(pc, tk, tg, c, r);
    #1;
    upd_valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: cold state, every pc in window falls through
    for (int i = 0; i < 32; i++) look_exp(32'(i * 4), 0, 32'(i * 4 + 4), "R1");

    // R3: taken allocates
    upd(32'h100, 1, 32'h400, 0, 0);
    look_exp(32'h100, 1, 32'h400, "R3");
    // R3: not taken allocates nothing
    upd(32'h204, 0, 32'h999C, 0, 0);
    look_exp(32'h204, 0, 32'h208, "R3");
    // R4: alias on index 0, different tag
    look_exp(32'h110, 0, 32'h114, "R4");
    // R2: plain miss
    look_exp(32'h1238, 0, 32'h123C, "R2");
    // R7: target replaced
    upd(32'h100, 1, 32'h800, 0, 0);
    look_exp(32'h100, 1, 32'h800, "R7");
    // R6: counter down to 1 keeps entry but predicts fall-through
    upd(32'h100, 0, 32'h0, 0, 0);
    upd(32'h100, 0, 32'h0, 0, 0);
    look_exp(32'h100, 0, 32'h104, "R6");
    // R5: saturate high, one not-taken still taken
    for (int i = 0; i < 4; i++) upd(32'h100, 1, 32'h800, 0, 0);
    upd(32'h100, 0, 32'h0, 0, 0);
    look_exp(32'h100, 1, 32'h800, "R5");
    // R5: saturate low, one taken gives 1 -> not taken
    for (int i = 0; i < 4; i++) upd(32'h100, 0, 32'h0, 0, 0);
    upd(32'h100, 1, 32'h800, 0, 0);
    look_exp(32'h100, 0, 32'h104, "R5");

    // R11: same-cycle update invisible, visible after the edge
    @(negedge clk_i);
    drive_upd(32'h300, 1, 32'h900, 0, 0);
    look_exp(32'h300, 0, 32'h304, "R11");
    @(posedge clk_i);
    model_upd(32'h300, 1, 32'h900, 0, 0);
    #1;
    upd_valid_i = 0;
    look_exp(32'h300, 1, 32'h900, "R11");

    // R9: return entry with empty stack uses counter and stored target
    upd(32'h500, 1, 32'h2000, 1, 0);
    upd(32'h2010, 1, 32'h504, 0, 1);
    look_exp(32'h2010, 1, 32'h504, "R9");
    // R8: call pushes pc+4, return entry predicts stack top
    upd(32'h604, 1, 32'h3000, 1, 0);
    look_exp(32'h2010, 1, 32'h608, "R8");
    upd(32'h2010, 1, 32'h608, 0, 1);

    // R10: five pushes into four slots, oldest lost
    for (int i = 0; i < 5; i++) upd(32'h1004 + 32'(i * 32'h100), 1, 32'h4000, 1, 0);
    look_exp(32'h2010, 1, 32'h1408, "R10");
    upd(32'h2010, 1, 32'h1408, 0, 1);
    look_exp(32'h2010, 1, 32'h1308, "R10");
    upd(32'h2010, 1, 32'h1308, 0, 1);
    look_exp(32'h2010, 1, 32'h1208, "R10");
    upd(32'h2010, 1, 32'h1208, 0, 1);
    look_exp(32'h2010, 1, 32'h1108, "R10");
    upd(32'h2010, 1, 32'h1108, 0, 1);
    look_exp(32'h2010, 1, 32'h1108, "R10");
    // R10: extra pop on empty stack stays empty
    upd(32'h2010, 1, 32'h5550, 0, 1);
    look_exp(32'h2010, 1, 32'h5550, "R10");

    // sweep against the model over a 32-address window
    for (int k = 0; k < 150; k++) begin
      logic [31:0] pc, tg;
      bit tk, c, r;
      pc = 32'(($urandom % 4) << 5) | 32'(($urandom % 8) << 2);
      tg = $urandom & 32'hFFFF_FFFC;
      tk = ($urandom % 3) != 0;
      c  = ($urandom % 6) == 0;
      r  = ($urandom % 5) == 0;
      upd(pc, tk, tg, c, r);
      for (int j = 0; j < 32; j++) look_model(32'(j * 4), "R3_R5_R8_sweep");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule